// File: doc/BRIEF.md
# Interrupt Status Unit with Interval Timer

This block gathers single-cycle event pulses from the receive, transmit and error logic of a network controller into a 16-bit pending-interrupt register. A companion enable register selects which pending bits may pull the active-low interrupt line. A pending bit records its event whether or not it is enabled, so software can poll events it has chosen not to be interrupted by. A single read of the pending register returns its contents and empties it.

The unit also holds a free-running 32-bit interval timer that counts bus clocks, and a compare register. When the timer reaches a nonzero compare value, a timeout event is raised into the pending register. A 24-bit dropped-frame counter counts frames lost to receive FIFO overflow. Software reaches all registers through a simple word-wide read/write port. Writing anything to the timer or to the dropped-frame counter restarts it at zero.

Top module: `intr_event_unit`

## Requirements
- R1: After hardware reset (rstN low) the pending, enable, compare and dropped-frame registers read zero and intN is high. The timer starts at zero and has advanced by one for each clock edge since reset was released.
- R2: A one-cycle pulse on an event input sets its pending bit at the next clock edge, whatever the enable register holds. The bit positions are: 0 evRxOk, 1 evRxErr, 2 evTxOk, 3 evTxErr, 4 evRxBufOvf, 5 evLinkChg, 6 evFifoOvf, 13 evCableChg, 14 timer timeout, 15 evSysErr. The register map is: address 0 pending, 1 enable, 2 timer, 3 compare, 4 dropped-frame counter.
- R3: intN is low exactly while the bitwise AND of pending and enable is nonzero.
- R4: A read of address 0 returns the pending bits and clears them at that clock edge. An event arriving in that same cycle stays pending afterwards.
- R5: A write to address 0 has no effect on the pending bits.
- R6: A write of any value to address 2 makes the timer zero after that edge. After that it counts up by one per clock and wraps from all ones to zero.
- R7: Pending bit 14 is set at the edge where the timer equals a nonzero compare value. It is never set while the compare register is zero.
- R8: The dropped-frame counter counts up once per clock in which evMissedPkt is high. A write to address 4, or swReset high, clears it. Read bits 31 to 24 are always zero.
- R9: Bits 12 to 7 of the pending and enable registers are reserved. They read as zero, whatever is written or signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous hardware reset, active low |
| swReset | input | 1 | Software reset; clears the dropped-frame counter |
| regAddr | input | 3 | Register address |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (a read of address 0 clears the pending bits) |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr (combinational) |
| evRxOk | input | 1 | Frame received without error |
| evRxErr | input | 1 | Frame received with error |
| evTxOk | input | 1 | Frame sent |
| evTxErr | input | 1 | Transmit aborted |
| evRxBufOvf | input | 1 | Receive buffer full |
| evLinkChg | input | 1 | Link change or transmit underrun |
| evFifoOvf | input | 1 | Receive FIFO overflow |
| evCableChg | input | 1 | Cable length change |
| evSysErr | input | 1 | System bus error |
| evMissedPkt | input | 1 | One frame dropped on FIFO overflow |
| intN | output | 1 | Interrupt request, active low |

## Verification
The hardest case to reach from the ports is an event pulse that lands in the same clock as the read that clears the pending register. The bench raises the pulse at the same falling edge where it starts the read, so one rising edge carries both the clear and the new event. It then checks that the read value lacks the event and that the next read shows it. The timeout path is reached by restarting the timer and then loading a small compare value. This places the match a known number of clocks ahead, where the bench samples the pending bit on both sides of the match. The same steps are repeated with a zero compare value to show that bit 14 stays clear.

// File: rtl/intr_pkg.sv
package intr_pkg;

  localparam int IRQ_W = 16;

  localparam int B_RXOK    = 0;
  localparam int B_RXERR   = 1;
  localparam int B_TXOK    = 2;
  localparam int B_TXERR   = 3;
  localparam int B_RXBUF   = 4;
  localparam int B_LINK    = 5;
  localparam int B_FIFO    = 6;
  localparam int B_CABLE   = 13;
  localparam int B_TIMEOUT = 14;
  localparam int B_SYSERR  = 15;

  // Implemented bits; 12..7 are reserved
  localparam logic [IRQ_W-1:0] IRQ_IMPL = 16'hE07F;

  typedef enum logic [2:0] {
    SEL_PEND  = 3'd0,
    SEL_MASK  = 3'd1,
    SEL_TIMER = 3'd2,
    SEL_CMP   = 3'd3,
    SEL_MISS  = 3'd4,
    SEL_NONE  = 3'd7
  } regSel_e;

  typedef struct packed {
    logic wrMask;
    logic wrTimer;
    logic wrCmp;
    logic clrMiss;
    logic clrPend;
  } strobe_t;

endpackage

// File: rtl/intr_ctrl.sv
module intr_ctrl
  import intr_pkg::*;
(
  input  logic [2:0] regAddr,
  input  logic       regWrEn,
  input  logic       regRdEn,
  input  logic       swReset,
  output strobe_t    strb,
  output regSel_e    rdSel
);

  always_comb begin
    strb  = '0;
    rdSel = SEL_NONE;
    case (regAddr)
      3'd0: rdSel = SEL_PEND;
      3'd1: rdSel = SEL_MASK;
      3'd2: rdSel = SEL_TIMER;
      3'd3: rdSel = SEL_CMP;
      3'd4: rdSel = SEL_MISS;
      default: rdSel = SEL_NONE;
    endcase
    strb.clrPend = regRdEn && (rdSel == SEL_PEND);
    strb.wrMask  = regWrEn && (rdSel == SEL_MASK);
    strb.wrTimer = regWrEn && (rdSel == SEL_TIMER);
    strb.wrCmp   = regWrEn && (rdSel == SEL_CMP);
    strb.clrMiss = swReset || (regWrEn && (rdSel == SEL_MISS));
  end

endmodule

// File: rtl/intr_timer.sv
module intr_timer
  import intr_pkg::*;
#(
  parameter int TIMER_W = 32
)(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [TIMER_W-1:0] wrData,
  output logic [TIMER_W-1:0] timerVal,
  output logic [TIMER_W-1:0] cmpVal,
  output logic               timeoutHit
);

  logic [TIMER_W-1:0] timerQ;
  logic [TIMER_W-1:0] cmpQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) timerQ <= '0;
    else if (strb.wrTimer) timerQ <= '0;
    else timerQ <= timerQ + TIMER_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cmpQ <= '0;
    else if (strb.wrCmp) cmpQ <= wrData;
  end

  assign timeoutHit = (cmpQ != '0) && (timerQ == cmpQ);
  assign timerVal   = timerQ;
  assign cmpVal     = cmpQ;

  AST_TIMER_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrTimer |=> (timerQ == '0)); // R6

  AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrTimer |=> (timerQ == TIMER_W'($past(timerQ) + TIMER_W'(1)))); // R6

endmodule

// File: rtl/intr_datapath.sv
module intr_datapath
  import intr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TIMER_W = 32,
  parameter int MISS_W = 24
)(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  regSel_e            rdSel,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [IRQ_W-1:0]   evVec,
  input  logic               timeoutHit,
  input  logic               missEv,
  input  logic [TIMER_W-1:0] timerVal,
  input  logic [TIMER_W-1:0] cmpVal,
  output logic [DATA_W-1:0]  rdData,
  output logic [IRQ_W-1:0]   pendOut,
  output logic [IRQ_W-1:0]   maskOut
);

  logic [IRQ_W-1:0]  evAll;
  logic [IRQ_W-1:0]  pend;
  logic [IRQ_W-1:0]  mask;
  logic [MISS_W-1:0] missCnt;

  always_comb begin
    evAll = evVec;
    evAll[B_TIMEOUT] = timeoutHit;
  end

  for (genvar i = 0; i < IRQ_W; i++) begin : g_bit
    if (IRQ_IMPL[i]) begin : g_impl
      logic pendQ;
      logic maskQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pendQ <= 1'b0;
        else pendQ <= (pendQ & ~strb.clrPend) | evAll[i];
      end
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) maskQ <= 1'b0;
        else if (strb.wrMask) maskQ <= wrData[i];
      end
      assign pend[i] = pendQ;
      assign mask[i] = maskQ;
    end else begin : g_rsvd
      assign pend[i] = 1'b0;
      assign mask[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) missCnt <= '0;
    else if (strb.clrMiss) missCnt <= '0;
    else if (missEv) missCnt <= missCnt + MISS_W'(1);
  end

  always_comb begin
    case (rdSel)
      SEL_PEND:  rdData = DATA_W'(pend);
      SEL_MASK:  rdData = DATA_W'(mask);
      SEL_TIMER: rdData = DATA_W'(timerVal);
      SEL_CMP:   rdData = DATA_W'(cmpVal);
      SEL_MISS:  rdData = DATA_W'(missCnt);
      default:   rdData = '0;
    endcase
  end

  assign pendOut = pend;
  assign maskOut = mask;

  AST_EVENT_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (evVec != '0) |=> ((pend & $past(evVec & IRQ_IMPL)) == $past(evVec & IRQ_IMPL))); // R2

  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrPend && evVec == '0 && !timeoutHit) |=> (pend == '0)); // R4

  AST_NO_ZERO_TIMEOUT: assert property (@(posedge clk) disable iff (!rstN)
    (cmpVal == '0) |=> !$rose(pend[B_TIMEOUT])); // R7

  AST_MISS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrMiss |=> (missCnt == '0)); // R8

endmodule

// File: rtl/intr_event_unit.sv
module intr_event_unit
  import intr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TIMER_W = 32,
  parameter int MISS_W = 24
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              swReset,
  input  logic [2:0]        regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              evRxOk,
  input  logic              evRxErr,
  input  logic              evTxOk,
  input  logic              evTxErr,
  input  logic              evRxBufOvf,
  input  logic              evLinkChg,
  input  logic              evFifoOvf,
  input  logic              evCableChg,
  input  logic              evSysErr,
  input  logic              evMissedPkt,
  output logic              intN
);

  strobe_t            strb;
  regSel_e            rdSel;
  logic [IRQ_W-1:0]   evVec;
  logic [TIMER_W-1:0] timerVal;
  logic [TIMER_W-1:0] cmpVal;
  logic               timeoutHit;
  logic [IRQ_W-1:0]   pend;
  logic [IRQ_W-1:0]   mask;

  always_comb begin
    evVec = '0;
    evVec[B_RXOK]   = evRxOk;
    evVec[B_RXERR]  = evRxErr;
    evVec[B_TXOK]   = evTxOk;
    evVec[B_TXERR]  = evTxErr;
    evVec[B_RXBUF]  = evRxBufOvf;
    evVec[B_LINK]   = evLinkChg;
    evVec[B_FIFO]   = evFifoOvf;
    evVec[B_CABLE]  = evCableChg;
    evVec[B_SYSERR] = evSysErr;
  end

  intr_ctrl u_ctrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .swReset (swReset),
    .strb    (strb),
    .rdSel   (rdSel)
  );

  intr_timer #(.TIMER_W(TIMER_W)) u_timer (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrData     (regWrData[TIMER_W-1:0]),
    .timerVal   (timerVal),
    .cmpVal     (cmpVal),
    .timeoutHit (timeoutHit)
  );

  intr_datapath #(.DATA_W(DATA_W), .TIMER_W(TIMER_W), .MISS_W(MISS_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .rdSel      (rdSel),
    .wrData     (regWrData),
    .evVec      (evVec),
    .timeoutHit (timeoutHit),
    .missEv     (evMissedPkt),
    .timerVal   (timerVal),
    .cmpVal     (cmpVal),
    .rdData     (regRdData),
    .pendOut    (pend),
    .maskOut    (mask)
  );

  assign intN = ~|(pend & mask);

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (mask == '0) |-> intN); // R3

  AST_PEND_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 3'd0 && !regRdEn && evVec == '0 && !timeoutHit) |=> (pend == $past(pend))); // R5

endmodule

// File: tb/intr_event_unit_tb.sv
module intr_event_unit_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        swReset;
  logic [2:0]  regAddr;
  logic        regWrEn;
  logic        regRdEn;
  logic [31:0] regWrData;
  logic [31:0] regRdData;
  logic evRxOk, evRxErr, evTxOk, evTxErr, evRxBufOvf, evLinkChg;
  logic evFifoOvf, evCableChg, evSysErr, evMissedPkt;
  logic        intN;

  int vecCnt = 0;
  int errCnt = 0;

  always #5 clk = ~clk;

  intr_event_unit u_dut (
    .clk(clk), .rstN(rstN), .swReset(swReset),
    .regAddr(regAddr), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regWrData(regWrData), .regRdData(regRdData),
    .evRxOk(evRxOk), .evRxErr(evRxErr), .evTxOk(evTxOk), .evTxErr(evTxErr),
    .evRxBufOvf(evRxBufOvf), .evLinkChg(evLinkChg), .evFifoOvf(evFifoOvf),
    .evCableChg(evCableChg), .evSysErr(evSysErr), .evMissedPkt(evMissedPkt),
    .intN(intN)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // bit layout: 0 rxOk,1 rxErr,2 txOk,3 txErr,4 rxBuf,5 link,6 fifo,13 cable,15 sysErr
  task automatic setEv(input logic [15:0] v);
    evRxOk = v[0]; evRxErr = v[1]; evTxOk = v[2]; evTxErr = v[3];
    evRxBufOvf = v[4]; evLinkChg = v[5]; evFifoOvf = v[6];
    evCableChg = v[13]; evSysErr = v[15];
  endtask

  // All tasks start and end at a falling edge
  task automatic pulseEv(input logic [15:0] v);
    setEv(v);
    @(negedge clk);
    setEv(16'h0);
  endtask

  task automatic readReg(input logic [2:0] a, output logic [31:0] d);
    regAddr = a; regRdEn = 1'b1;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] d;
    check("R1 intN", {31'b0, intN}, 32'h1);
    readReg(3'd0, d); check("R1 pending", d, 32'h0);
    readReg(3'd1, d); check("R1 enable", d, 32'h0);
    readReg(3'd3, d); check("R1 compare", d, 32'h0);
    readReg(3'd4, d); check("R1 dropped", d, 32'h0);
    readReg(3'd2, d); check("R1 timer", d, 32'd4);
  endtask

  task automatic testEventMap();
    logic [31:0] d;
    int pos [9] = '{0, 1, 2, 3, 4, 5, 6, 13, 15};
    foreach (pos[k]) begin
      pulseEv(16'(1) << pos[k]);
      check("R2 intN masked", {31'b0, intN}, 32'h1);
      readReg(3'd0, d);
      check("R2 bit", d, 32'(1) << pos[k]);
    end
  endtask

  task automatic testIrqLine();
    logic [31:0] d;
    writeReg(3'd1, 32'h0000_0004);
    pulseEv(16'h0001);
    check("R3 unmasked-only pending", {31'b0, intN}, 32'h1);
    pulseEv(16'h0004);
    check("R3 asserted", {31'b0, intN}, 32'h0);
    readReg(3'd0, d);
    check("R3 pending", d, 32'h5);
    check("R3 released", {31'b0, intN}, 32'h1);
    writeReg(3'd1, 32'h0);
  endtask

  task automatic testReadRace();
    logic [31:0] d;
    pulseEv(16'h0002);
    regAddr = 3'd0; regRdEn = 1'b1; setEv(16'h0004);
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0; setEv(16'h0);
    check("R4 read value", d, 32'h2);
    readReg(3'd0, d);
    check("R4 same-cycle event kept", d, 32'h4);
    readReg(3'd0, d);
    check("R4 cleared", d, 32'h0);
  endtask

  task automatic testPendWrite();
    logic [31:0] d;
    pulseEv(16'h0008);
    writeReg(3'd0, 32'hFFFF_FFFF);
    writeReg(3'd0, 32'h0);
    readReg(3'd0, d);
    check("R5 write ignored", d, 32'h8);
  endtask

  task automatic testReserved();
    logic [31:0] d;
    writeReg(3'd1, 32'h0000_FFFF);
    readReg(3'd1, d);
    check("R9 enable reserved", d, 32'h0000_E07F);
    writeReg(3'd1, 32'h0);
    pulseEv(16'hFFFF);
    readReg(3'd0, d);
    check("R9 pending reserved", d, 32'h0000_A07F);
  endtask

  task automatic testTimer();
    logic [31:0] d;
    writeReg(3'd2, 32'hDEAD_BEEF);
    readReg(3'd2, d); check("R6 restart", d, 32'd0);
    readReg(3'd2, d); check("R6 count", d, 32'd1);
    repeat (5) @(negedge clk);
    readReg(3'd2, d); check("R6 count later", d, 32'd7);
  endtask

  task automatic testTimeout();
    logic [31:0] d;
    writeReg(3'd2, 32'h0);
    writeReg(3'd3, 32'd20);
    readReg(3'd0, d); check("R7 before match", d, 32'h0);
    repeat (10) @(negedge clk);
    readReg(3'd0, d); check("R7 not yet", d, 32'h0);
    repeat (15) @(negedge clk);
    readReg(3'd0, d); check("R7 timeout set", d, 32'h4000);
    check("R7 masked no irq", {31'b0, intN}, 32'h1);
    writeReg(3'd3, 32'h0);
    writeReg(3'd2, 32'h1);
    readReg(3'd0, d);
    repeat (30) @(negedge clk);
    readReg(3'd0, d); check("R7 zero compare silent", d, 32'h0);
  endtask

  task automatic testMissed();
    logic [31:0] d;
    evMissedPkt = 1'b1;
    repeat (3) @(negedge clk);
    evMissedPkt = 1'b0;
    readReg(3'd4, d); check("R8 count", d, 32'd3);
    check("R8 upper byte", {24'b0, d[31:24]}, 32'h0);
    writeReg(3'd4, 32'hFFFF_FFFF);
    readReg(3'd4, d); check("R8 write clears", d, 32'd0);
    evMissedPkt = 1'b1;
    @(negedge clk);
    evMissedPkt = 1'b0;
    swReset = 1'b1;
    @(negedge clk);
    swReset = 1'b0;
    readReg(3'd4, d); check("R8 soft reset clears", d, 32'd0);
  endtask

  initial begin
    #2000000;
    errCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

  initial begin
    rstN = 1'b0; swReset = 1'b0; regAddr = '0; regWrEn = 1'b0; regRdEn = 1'b0;
    regWrData = '0; evMissedPkt = 1'b0; setEv(16'h0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testEventMap();
    testIrqLine();
    testReadRace();
    testPendWrite();
    testReserved();
    testTimer();
    testTimeout();
    testMissed();
    $display("  == %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

endmodule